// File: doc/BRIEF.md
# Configurable 16x16 Multiply-Accumulate Unit

This block multiplies two operands of up to 16 bits and combines the product with a 32-bit addend in a post adder/subtractor. Each operand is widened to 16 bits by sign or zero extension, according to its own signedness parameter. The addend is assembled from two 16-bit halves. The sum may be registered, and when it is, the register can feed back into the adder. That makes a running accumulator that a single control input can preload from the addend.

Parameters pick which register stages exist. There are input registers for each operand and for the addend pair, two pipeline stages behind the multiplier, and an output register. Parameters also pick the active clock edge. With no clock at all, the whole unit is one combinational path. Register stages carry hold and synchronous clear controls, and a clear always wins over a hold. A global synchronous reset empties every stage.

An output mode presents only the registered lower half of the sum. The result is 33 bits wide: bit 32 leaves as a carry/borrow flag, or as a copy of bit 31 when both operands are signed.

Top module: `mac16_unit`

## Requirements
- R1: With its signedness parameter set, an operand narrower than 16 bits is sign-extended to 16 bits. Otherwise it is zero-extended.
- R2: The addend is `{c_in, d_in}`: `c_in` supplies bits 31:16 and `d_in` supplies bits 15:0.
- R3: While `a_hold`, `b_hold` or `cd_hold` is high, the matching input register keeps its contents and ignores new input values.
- R4: `top_clr` zeroes the operand-A input register and `bot_clr` zeroes the operand-B input register. A clear wins over a simultaneous hold.
- R5: With all six register stages present, a product first appears at `result` four clock edges after its operands are driven.
- R6: With `sub_en` low the adder forms addend + product. With `sub_en` high it forms addend − product.
- R7: With accumulation enabled and `acc_load` low, the adder's addend operand is the output register's previous 32-bit value.
- R8: With `acc_load` high, the addend operand is the `{c_in, d_in}` path instead of the feedback, so the accumulator restarts from any value.
- R9: When both operands are unsigned, `carry_out` is the true 33rd bit of the add or subtract. When both are signed, `carry_out` equals `result[31]`.
- R10: `out_hold` keeps `result` and `carry_out` unchanged. `out_clr` zeroes both on the next active edge and wins over `out_hold`.
- R11: In low-half mode, `result[15:0]` is the registered lower 16 bits of the sum, while `result[31:16]` and `carry_out` are 0.
- R12: With the falling-edge parameter set, every register updates on the falling clock edge and holds its value across the rising edge.
- R13: With no clock configured, all stages are bypassed and `result` follows the inputs combinationally.
- R14: `rst` clears every register stage, so `result` and `carry_out` read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; active edge set by parameter |
| rst | input | 1 | Synchronous reset of all stages |
| a_in | input | A_W | Operand A |
| b_in | input | B_W | Operand B |
| c_in | input | 16 | Addend upper half |
| d_in | input | 16 | Addend lower half |
| a_hold | input | 1 | Hold for the operand-A register |
| b_hold | input | 1 | Hold for the operand-B register |
| cd_hold | input | 1 | Shared hold for the addend register |
| top_clr | input | 1 | Synchronous clear of the operand-A register |
| bot_clr | input | 1 | Synchronous clear of the operand-B register |
| sub_en | input | 1 | 1 = subtract product, 0 = add |
| acc_load | input | 1 | Replace accumulator feedback with the addend |
| out_hold | input | 1 | Hold for the output register |
| out_clr | input | 1 | Synchronous clear of the output register |
| result | output | 32 | Sum, or registered lower half in low-half mode |
| carry_out | output | 1 | Bit 32 of the sum |

## Verification
The assertions assume that `rst` is high from time zero until at least one active edge has passed. They also assume that the holds and clears are plain binary levels that change only away from the active edge. The stimulus meets both conditions. It raises reset before the first edge and changes every input one nanosecond after the rising edge. For the falling-edge configuration it changes inputs well before the falling edge. The sign-tie property applies only to the signed configuration, so it expects the stimulus to mix positive and negative operands. The bench drives full-range values there so that the property also sees bit 31 set.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
   localparam int OP_W   = 16;
   localparam int HALF_W = 8;
   localparam int PROD_W = 2 * OP_W;
   localparam int SUM_W  = PROD_W + 1;
   localparam int PP_W   = 2 * (HALF_W + 1);

   typedef struct packed {
      logic signed [PP_W-1:0] hh;
      logic signed [PP_W-1:0] hl;
      logic signed [PP_W-1:0] lh;
      logic signed [PP_W-1:0] ll;
   } pp_t;

   function automatic logic [PROD_W-1:0] pp_sum(input pp_t p);
      logic [PROD_W-1:0] hh, hl, lh, ll;
      hh = {{(PROD_W-PP_W){p.hh[PP_W-1]}}, p.hh};
      hl = {{(PROD_W-PP_W){p.hl[PP_W-1]}}, p.hl};
      lh = {{(PROD_W-PP_W){p.lh[PP_W-1]}}, p.lh};
      ll = {{(PROD_W-PP_W){p.ll[PP_W-1]}}, p.ll};
      return (hh << (2*HALF_W)) + (hl << HALF_W) + (lh << HALF_W) + ll;
   endfunction
endpackage

// File: rtl/mac16_stage_reg.sv
module mac16_stage_reg #(
   parameter int W   = 16,
   parameter int EN  = 1,
   parameter int NEG = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("mac16_stage_reg: W must be positive");
   end

   if (EN == 0) begin : g_bypass
      logic unused_ctl;
      assign unused_ctl = ^{clk, rst, clr, hold};
      assign q = d;
   end else begin : g_reg
      logic [W-1:0] r;
      logic [W-1:0] nxt;
      always_comb begin
         if (rst || clr)  nxt = '0;
         else if (hold)   nxt = r;
         else             nxt = d;
      end
      if (NEG != 0) begin : g_fall
         always_ff @(negedge clk) r <= nxt;
      end else begin : g_rise
         always_ff @(posedge clk) r <= nxt;
      end
      assign q = r;
   end
endmodule

// File: rtl/mac16_mult.sv
module mac16_mult
   import mac16_pkg::*;
#(
   parameter int A_SGN = 1,
   parameter int B_SGN = 1
) (
   input  logic [OP_W-1:0] a,
   input  logic [OP_W-1:0] b,
   output pp_t             pp
);
   logic signed [HALF_W:0] ah, al, bh, bl;

   assign ah = {(A_SGN != 0) ? a[OP_W-1] : 1'b0, a[OP_W-1:HALF_W]};
   assign al = {1'b0, a[HALF_W-1:0]};
   assign bh = {(B_SGN != 0) ? b[OP_W-1] : 1'b0, b[OP_W-1:HALF_W]};
   assign bl = {1'b0, b[HALF_W-1:0]};

   assign pp.hh = ah * bh;
   assign pp.hl = ah * bl;
   assign pp.lh = al * bh;
   assign pp.ll = al * bl;
endmodule

// File: rtl/mac16_addsub.sv
module mac16_addsub
   import mac16_pkg::*;
#(
   parameter int SGN = 1
) (
   input  logic [PROD_W-1:0] x,
   input  logic [PROD_W-1:0] y,
   input  logic              sub,
   output logic [SUM_W-1:0]  sum
);
   logic [SUM_W-1:0] wide;

   assign wide = sub ? ({1'b0, y} - {1'b0, x}) : ({1'b0, y} + {1'b0, x});

   if (SGN != 0) begin : g_signed
      assign sum = {wide[PROD_W-1], wide[PROD_W-1:0]};
   end else begin : g_unsigned
      assign sum = wide;
   end
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
   import mac16_pkg::*;
#(
   parameter int A_W       = 16,
   parameter int B_W       = 16,
   parameter int A_SIGNED  = 1,
   parameter int B_SIGNED  = 1,
   parameter int HAS_CLK   = 1,
   parameter int NEG_EDGE  = 0,
   parameter int A_REG     = 1,
   parameter int B_REG     = 1,
   parameter int CD_REG    = 1,
   parameter int MULT_REG1 = 1,
   parameter int MULT_REG2 = 1,
   parameter int OUT_REG   = 1,
   parameter int ACCUM     = 1,
   parameter int LOW_ONLY  = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [A_W-1:0]     a_in,
   input  logic [B_W-1:0]     b_in,
   input  logic [OP_W-1:0]    c_in,
   input  logic [OP_W-1:0]    d_in,
   input  logic               a_hold,
   input  logic               b_hold,
   input  logic               cd_hold,
   input  logic               top_clr,
   input  logic               bot_clr,
   input  logic               sub_en,
   input  logic               acc_load,
   input  logic               out_hold,
   input  logic               out_clr,
   output logic [PROD_W-1:0]  result,
   output logic               carry_out
);
   localparam int CLK_ON  = (HAS_CLK != 0) ? 1 : 0;
   localparam int EN_A    = (A_REG != 0) ? CLK_ON : 0;
   localparam int EN_B    = (B_REG != 0) ? CLK_ON : 0;
   localparam int EN_CD   = (CD_REG != 0) ? CLK_ON : 0;
   localparam int EN_P1   = (MULT_REG1 != 0) ? CLK_ON : 0;
   localparam int EN_P2   = (MULT_REG2 != 0) ? CLK_ON : 0;
   localparam int EN_O    = (OUT_REG != 0) ? CLK_ON : 0;
   localparam int BOTH_S  = (A_SIGNED != 0 && B_SIGNED != 0) ? 1 : 0;
   localparam int LOW_W   = OP_W;

   if (A_W < 2 || A_W > OP_W) begin : g_bad_aw
      $error("mac16_unit: A_W must lie in 2..16");
   end
   if (B_W < 2 || B_W > OP_W) begin : g_bad_bw
      $error("mac16_unit: B_W must lie in 2..16");
   end
   if (ACCUM != 0 && EN_O == 0) begin : g_bad_acc
      $error("mac16_unit: accumulation needs a clocked output register");
   end
   if (LOW_ONLY != 0 && EN_O == 0) begin : g_bad_low
      $error("mac16_unit: low-half mode needs a clocked output register");
   end

   // operand widening
   logic [OP_W-1:0] a_ext, b_ext;
   for (genvar i = 0; i < OP_W; i++) begin : g_aext
      if (i < A_W) begin : g_in
         assign a_ext[i] = a_in[i];
      end else begin : g_fill
         assign a_ext[i] = (A_SIGNED != 0) ? a_in[A_W-1] : 1'b0;
      end
   end
   for (genvar i = 0; i < OP_W; i++) begin : g_bext
      if (i < B_W) begin : g_in
         assign b_ext[i] = b_in[i];
      end else begin : g_fill
         assign b_ext[i] = (B_SIGNED != 0) ? b_in[B_W-1] : 1'b0;
      end
   end

   // input stage
   logic [OP_W-1:0]   a_q, b_q;
   logic [PROD_W-1:0] cd_q;

   mac16_stage_reg #(.W(OP_W), .EN(EN_A), .NEG(NEG_EDGE)) u_reg_a (
      .clk(clk), .rst(rst), .clr(top_clr), .hold(a_hold), .d(a_ext), .q(a_q));
   mac16_stage_reg #(.W(OP_W), .EN(EN_B), .NEG(NEG_EDGE)) u_reg_b (
      .clk(clk), .rst(rst), .clr(bot_clr), .hold(b_hold), .d(b_ext), .q(b_q));
   mac16_stage_reg #(.W(PROD_W), .EN(EN_CD), .NEG(NEG_EDGE)) u_reg_cd (
      .clk(clk), .rst(rst), .clr(1'b0), .hold(cd_hold), .d({c_in, d_in}), .q(cd_q));

   // multiplier and pipeline
   pp_t pp_d, pp_q;
   logic [PROD_W-1:0] prod_d, prod_q;

   mac16_mult #(.A_SGN(A_SIGNED), .B_SGN(B_SIGNED)) u_mult (
      .a(a_q), .b(b_q), .pp(pp_d));

   mac16_stage_reg #(.W($bits(pp_t)), .EN(EN_P1), .NEG(NEG_EDGE)) u_reg_pp (
      .clk(clk), .rst(rst), .clr(1'b0), .hold(1'b0), .d(pp_d), .q(pp_q));

   assign prod_d = pp_sum(pp_q);

   mac16_stage_reg #(.W(PROD_W), .EN(EN_P2), .NEG(NEG_EDGE)) u_reg_prod (
      .clk(clk), .rst(rst), .clr(1'b0), .hold(1'b0), .d(prod_d), .q(prod_q));

   // post adder
   logic [SUM_W-1:0]  sum_d, out_q;
   logic [PROD_W-1:0] addend;

   if (ACCUM != 0) begin : g_acc
      assign addend = acc_load ? cd_q : out_q[PROD_W-1:0];
   end else begin : g_plain
      logic unused_load;
      assign unused_load = acc_load;
      assign addend = cd_q;
   end

   mac16_addsub #(.SGN(BOTH_S)) u_add (
      .x(prod_q), .y(addend), .sub(sub_en), .sum(sum_d));

   mac16_stage_reg #(.W(SUM_W), .EN(EN_O), .NEG(NEG_EDGE)) u_reg_out (
      .clk(clk), .rst(rst), .clr(out_clr), .hold(out_hold), .d(sum_d), .q(out_q));

   // output select
   if (LOW_ONLY != 0) begin : g_low
      logic unused_hi;
      assign unused_hi = ^out_q[SUM_W-1:LOW_W];
      assign result    = {{(PROD_W-LOW_W){1'b0}}, out_q[LOW_W-1:0]};
      assign carry_out = 1'b0;
   end else begin : g_full
      assign result    = out_q[PROD_W-1:0];
      assign carry_out = out_q[SUM_W-1];
   end
endmodule

// File: rtl/mac16_unit_chk.sv
module mac16_unit_chk #(
   parameter int HAS_CLK  = 1,
   parameter int NEG_EDGE = 0,
   parameter int OUT_REG  = 1,
   parameter int LOW_ONLY = 0,
   parameter int BOTH_S   = 1
) (
   input logic        clk,
   input logic        rst,
   input logic        out_hold,
   input logic        out_clr,
   input logic [31:0] result,
   input logic        carry_out
);
   logic ck;
   assign ck = (NEG_EDGE != 0) ? ~clk : clk;

   if (HAS_CLK != 0) begin : g_clocked
      if (OUT_REG != 0) begin : g_oreg
         AST_OUT_CLEAR_ZERO: assert property (@(posedge ck) disable iff (rst)
            out_clr |=> (result == 32'd0 && carry_out == 1'b0)); // R10
         AST_OUT_HOLD_STABLE: assert property (@(posedge ck) disable iff (rst)
            (out_hold && !out_clr) |=> ($stable(result) && $stable(carry_out))); // R10
         AST_RESET_EMPTY: assert property (@(posedge ck) disable iff (rst)
            $fell(rst) |-> (result == 32'd0 && carry_out == 1'b0)); // R14
      end
      if (BOTH_S != 0 && LOW_ONLY == 0) begin : g_sign
         AST_SIGN_TIE: assert property (@(posedge ck) disable iff (rst)
            carry_out == result[31]); // R9
      end
   end else begin : g_comb
      logic unused_in;
      assign unused_in = ^{ck, rst, out_hold, out_clr};
      if (BOTH_S != 0) begin : g_sign
         always_comb begin
            AST_SIGN_TIE_COMB: assert (carry_out === result[31] || $isunknown(result)); // R9
         end
      end
   end
endmodule

bind mac16_unit mac16_unit_chk #(
   .HAS_CLK(HAS_CLK), .NEG_EDGE(NEG_EDGE), .OUT_REG(OUT_REG),
   .LOW_ONLY(LOW_ONLY), .BOTH_S((A_SIGNED != 0 && B_SIGNED != 0) ? 1 : 0)
) u_chk (
   .clk(clk), .rst(rst), .out_hold(out_hold), .out_clr(out_clr),
   .result(result), .carry_out(carry_out)
);

// File: tb/mac16_unit_tb.sv
`timescale 1ns/100ps
module mac16_unit_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int nchk = 0;
   int nbad = 0;

   // fully registered signed accumulator (defaults)
   logic [15:0] d_a = '0, d_b = '0, d_c = '0, d_d = '0;
   logic d_ah = 0, d_bh = 0, d_cdh = 0, d_ac = 0, d_bc = 0;
   logic d_sub = 0, d_ld = 0, d_oh = 0, d_oc = 0;
   logic [31:0] d_res;
   logic        d_co;

   mac16_unit u_dut (
      .clk(clk), .rst(rst), .a_in(d_a), .b_in(d_b), .c_in(d_c), .d_in(d_d),
      .a_hold(d_ah), .b_hold(d_bh), .cd_hold(d_cdh), .top_clr(d_ac), .bot_clr(d_bc),
      .sub_en(d_sub), .acc_load(d_ld), .out_hold(d_oh), .out_clr(d_oc),
      .result(d_res), .carry_out(d_co));

   // unclocked unsigned unit
   logic [15:0] c_a = '0, c_b = '0, c_c = '0, c_d = '0;
   logic c_sub = 0;
   logic [31:0] c_res;
   logic        c_co;

   mac16_unit #(.A_SIGNED(0), .B_SIGNED(0), .HAS_CLK(0), .ACCUM(0)) u_comb (
      .clk(clk), .rst(rst), .a_in(c_a), .b_in(c_b), .c_in(c_c), .d_in(c_d),
      .a_hold(1'b0), .b_hold(1'b0), .cd_hold(1'b0), .top_clr(1'b0), .bot_clr(1'b0),
      .sub_en(c_sub), .acc_load(1'b0), .out_hold(1'b0), .out_clr(1'b0),
      .result(c_res), .carry_out(c_co));

   // 8-bit operands, falling edge, registered low half only
   logic [7:0]  l_a = '0, l_b = '0;
   logic [15:0] l_c = '0, l_d = '0;
   logic l_sub = 0;
   logic [31:0] l_res;
   logic        l_co;

   mac16_unit #(.A_W(8), .B_W(8), .A_SIGNED(1), .B_SIGNED(0), .NEG_EDGE(1),
                .A_REG(0), .B_REG(0), .CD_REG(0), .MULT_REG1(0), .MULT_REG2(0),
                .OUT_REG(1), .ACCUM(0), .LOW_ONLY(1)) u_low (
      .clk(clk), .rst(rst), .a_in(l_a), .b_in(l_b), .c_in(l_c), .d_in(l_d),
      .a_hold(1'b0), .b_hold(1'b0), .cd_hold(1'b0), .top_clr(1'b0), .bot_clr(1'b0),
      .sub_en(l_sub), .acc_load(1'b0), .out_hold(1'b0), .out_clr(1'b0),
      .result(l_res), .carry_out(l_co));

   // cycle reference for u_dut
   logic [15:0] ma, mb;
   logic [31:0] mcd, mp1, mp2, mfb, ms32;
   logic [32:0] macc;

   always_comb begin
      mfb  = d_ld ? mcd : macc[31:0];
      ms32 = d_sub ? (mfb - mp2) : (mfb + mp2);
   end

   always @(posedge clk) begin
      if (rst) begin
         ma <= '0; mb <= '0; mcd <= '0; mp1 <= '0; mp2 <= '0; macc <= '0;
      end else begin
         ma   <= d_ac ? 16'd0 : (d_ah ? ma : d_a);
         mb   <= d_bc ? 16'd0 : (d_bh ? mb : d_b);
         mcd  <= d_cdh ? mcd : {d_c, d_d};
         mp1  <= 32'(longint'($signed(ma)) * longint'($signed(mb)));
         mp2  <= mp1;
         macc <= d_oc ? 33'd0 : (d_oh ? macc : {ms32[31], ms32});
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic dsample(input string tag);
      #3;
      chk(tag, {31'd0, d_co, d_res}, {31'd0, macc});
   endtask

   task automatic dnext();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
   endtask

   initial begin
      #(5.0 * 150000);
      nbad++;
      $display("FAIL watchdog R5 actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      dnext();
      // R14: reset empties every stage
      for (int k = 0; k < 3; k++) begin
         dsample("R14");
         dnext();
      end
      #3;
      chk("R14 u_dut zero", {31'd0, d_co, d_res}, 64'd0);
      chk("R14 u_low zero", {31'd0, l_co, l_res}, 64'd0);
      dnext();
      rst = 1'b0;

      // R8: preload accumulator from addend
      d_ld = 1; d_c = 16'h0000; d_d = 16'd100;
      for (int k = 0; k < 6; k++) begin dsample("R8"); dnext(); end
      #3;
      chk("R8 preload", {32'd0, d_res}, 64'd100);
      dnext();

      // R5: four-edge latency, addend 100 held by load
      for (int k = 0; k < 6; k++) begin
         if (k == 0) begin d_a = 16'd7; d_b = 16'd9; end
         else begin d_a = 16'd0; d_b = 16'd0; end
         dsample("R5");
         chk("R5 latency", {32'd0, d_res}, (k == 4) ? 64'd163 : 64'd100);
         dnext();
      end

      // R6 and R2: add and subtract with random operands, addend {c,d}
      for (int k = 0; k < 60; k++) begin
         d_a = 16'($urandom); d_b = 16'($urandom);
         d_c = 16'($urandom); d_d = 16'($urandom);
         d_sub = k[0];
         dsample("R6");
         dnext();
      end

      // R9: signed carry equals bit 31 with extreme operands
      for (int k = 0; k < 20; k++) begin
         d_a = k[0] ? 16'h8000 : 16'h7fff; d_b = k[1] ? 16'h8000 : 16'hffff;
         d_c = k[2] ? 16'h8000 : 16'h7fff; d_d = 16'($urandom);
         dsample("R9");
         chk("R9 sign tie", {63'd0, d_co}, {63'd0, d_res[31]});
         dnext();
      end

      // R7: accumulate with feedback
      d_sub = 0; d_ld = 1; d_c = 0; d_d = 0; d_a = 0; d_b = 0;
      for (int k = 0; k < 5; k++) begin dsample("R7"); dnext(); end
      d_ld = 0; d_a = 16'd2; d_b = 16'd3;
      for (int k = 0; k < 30; k++) begin
         d_sub = (k > 20);
         dsample("R7");
         dnext();
      end

      // R3: input holds
      d_ld = 1; d_sub = 0; d_a = 16'd11; d_b = 16'd13; d_c = 16'd0; d_d = 16'd16;
      dsample("R3"); dnext();
      d_ah = 1; d_bh = 1; d_cdh = 1;
      for (int k = 0; k < 7; k++) begin
         d_a = 16'($urandom); d_b = 16'($urandom);
         d_c = 16'($urandom); d_d = 16'($urandom);
         dsample("R3");
         dnext();
      end
      #3;
      chk("R3 held sum", {32'd0, d_res}, 64'd159);
      dnext();

      // R4: clears beat holds
      d_ac = 1; d_bc = 1;
      dsample("R4"); dnext();
      d_ac = 0; d_bc = 0;
      for (int k = 0; k < 5; k++) begin dsample("R4"); dnext(); end
      #3;
      chk("R4 cleared operands", {32'd0, d_res}, 64'd16);
      dnext();
      d_ah = 0; d_bh = 0; d_cdh = 0;
      for (int k = 0; k < 40; k++) begin
         d_a = 16'($urandom); d_b = 16'($urandom);
         d_ah = k[1]; d_bh = k[2]; d_ac = (k % 5 == 0); d_bc = (k % 7 == 0);
         dsample("R4");
         dnext();
      end
      d_ah = 0; d_bh = 0; d_ac = 0; d_bc = 0;

      // R10: output hold and clear
      d_ld = 0;
      for (int k = 0; k < 60; k++) begin
         d_a = 16'($urandom); d_b = 16'($urandom);
         d_oh = k[0] ^ k[2]; d_oc = (k % 9 == 3); d_sub = k[3];
         dsample("R10");
         dnext();
      end
      d_oh = 0; d_oc = 0;

      // R13, R2, R6, R9: unclocked unsigned unit over corner values
      begin
         logic [15:0] av [6];
         logic [31:0] cv [4];
         av = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};
         cv = '{32'h0000_0000, 32'hffff_ffff, 32'h8000_0000, 32'h0001_0000};
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               for (int m = 0; m < 4; m++)
                  for (int s = 0; s < 2; s++) begin
                     longint p, e;
                     c_a = av[i]; c_b = av[j];
                     c_c = cv[m][31:16]; c_d = cv[m][15:0]; c_sub = s[0];
                     #1;
                     p = longint'(c_a) * longint'(c_b);
                     e = s[0] ? (longint'(cv[m]) - p) : (longint'(cv[m]) + p);
                     chk("R13 R2 R6 R9 comb", {31'd0, c_co, c_res}, {31'd0, e[32:0]});
                  end
      end
      dnext();

      // R1, R11, R12: signed 8-bit A, falling-edge, low half
      begin
         logic [63:0] prev;
         prev = 64'd0;
         for (int ia = 0; ia < 256; ia++)
            for (int ib = 0; ib < 256; ib += 5) begin
               longint e;
               l_a = 8'(ia); l_b = 8'(ib);
               l_c = 16'($urandom); l_d = 16'($urandom); l_sub = ia[0] ^ ib[0];
               e = longint'({l_c, l_d});
               if (l_sub) e = e - longint'($signed(l_a)) * longint'(l_b);
               else       e = e + longint'($signed(l_a)) * longint'(l_b);
               #1;
               chk("R12 before fall", {31'd0, l_co, l_res}, prev);
               #2;
               chk("R1 R11 low half", {31'd0, l_co, l_res}, {48'd0, e[15:0]});
               prev = {48'd0, e[15:0]};
               dnext();
            end
      end

      summary();
      $finish;
   end
endmodule